// File: doc/BRIEF.md
# Receive Packet Store with Descriptor Queue

This block holds received packets in a shared circular byte store and keeps a small queue of descriptors, one per packet, each giving the packet's start address and payload length. A demodulator-side writer announces a packet with a start pulse and its payload length. If there is room, the block reserves a contiguous segment of payload length plus 16 bytes and queues the descriptor in the same cycle. The writer then streams the payload followed by 16 metadata bytes: a channel byte, a byte packing spreading factor, coding rate and CRC-enable, then signal-quality fields. The block stores these bytes as they come and does not interpret them.

The host works through a small register port. Writing the advance command makes the oldest queued descriptor current, and its start and length can then be read back. The host loads a read pointer and pulls bytes one at a time, and the pointer steps forward after each read. The current packet keeps its segment until the host advances past it, and only then is the space given back. A status output always shows how many descriptors are waiting. A sticky flag records that a packet was refused.

Top module: `rx_pkt_buffer`

## Requirements
- R1: After reset the pending count is 0, the overflow flag is 0, host_rdata is 0, and the current start and length both read as 0.
- R2: An accepted wr_start queues a descriptor, and pkt_count is one higher from the next cycle.
- R3: When 16 descriptors are pending, a new wr_start is refused. pkt_count stays 16 and no store space is reserved for it.
- R4: A wr_start whose length plus 16 exceeds the free bytes is refused. Any refusal sets ovf, which stays 1 until reset.
- R5: A host write to address 0 with bit 0 set makes the oldest pending descriptor current and lowers pkt_count by one. Reads of address 1 and address 2 then return its start and its payload length.
- R6: Accepted packets take consecutive segments. The first packet after reset starts at 0, and each later one starts at the previous start plus the previous length plus 16, modulo 1024.
- R7: Bytes streamed after an accepted wr_start are stored at consecutive addresses from the segment start. A host write to address 1 loads the read pointer. Each read of address 3 returns the byte at the pointer, and the pointer then steps by one.
- R8: Store addresses and the read pointer wrap from 1023 to 0, so a segment may straddle the end of the store.
- R9: A packet's bytes stay reserved while its descriptor is pending or current. They are freed only when an advance command moves past that packet, after which a packet that did not fit before can be accepted.
- R10: An advance command while no descriptor is pending changes nothing: the count, the current descriptor and the reserved space all stay as they were.
- R11: host_rdata shows the result of a host read from the cycle after host_rd and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_start | input | 1 | Writer announces a new packet |
| wr_len | input | 8 | Payload length of the announced packet |
| wr_valid | input | 1 | Writer byte strobe |
| wr_byte | input | 8 | Writer byte |
| host_wr | input | 1 | Host register write |
| host_rd | input | 1 | Host register read |
| host_addr | input | 2 | Register: 0 status/advance, 1 start/pointer, 2 length, 3 data |
| host_wdata | input | 10 | Host write data |
| host_rdata | output | 10 | Host read data, one cycle after host_rd |
| pkt_count | output | 5 | Number of pending descriptors |
| ovf | output | 1 | Sticky refused-packet flag |

## Verification
The assertions check properties that hold on every cycle. The pending count never exceeds the queue depth and moves by at most one per cycle. A grant raises the count. The overflow flag is sticky. Reserved space changes only on a grant or an advance and never exceeds the store size. An advance with an empty queue changes nothing. Other behaviour can only be shown by the bench scenarios: the segment placement, the content and order of the stored bytes, wrapping across the store end, space being freed when the host moves on, and the refusal of a packet that is too large.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;

  // host register addresses; reads and writes share the decode
  typedef enum logic [1:0] {
    RXB_A_CTRL  = 2'd0,  // read: pending count, write: advance command
    RXB_A_START = 2'd1,  // read: current start, write: read pointer
    RXB_A_LEN   = 2'd2,  // read: current payload length
    RXB_A_DATA  = 2'd3   // read: byte at pointer, then pointer + 1
  } rxb_addr_e;

  localparam int unsigned RXB_CMD_NEXT_BIT = 0;

endpackage

// File: rtl/rxbuf_desc_fifo.sv
module rxbuf_desc_fifo #(
  parameter  int unsigned DEPTH = 16,
  parameter  int unsigned W     = 18,
  localparam int unsigned PW    = $clog2(DEPTH),
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);

  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = slot_q[rp_q];
  assign count   = cnt_q;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push_ok) begin
      wp_d = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    end
    if (pop_ok) begin
      rp_d = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    end
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      slot_q[wp_q] <= din;
    end
  end

endmodule

// File: rtl/rxbuf_alloc.sv
module rxbuf_alloc #(
  parameter  int unsigned MEM_BYTES  = 1024,
  parameter  int unsigned LEN_W      = 8,
  parameter  int unsigned META_BYTES = 16,
  localparam int unsigned AW         = $clog2(MEM_BYTES),
  localparam int unsigned UW         = $clog2(MEM_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [LEN_W-1:0] req_len,
  input  logic             blocked,
  input  logic             rel,
  input  logic [LEN_W-1:0] rel_len,
  output logic             grant,
  output logic             drop,
  output logic [AW-1:0]    seg_start,
  output logic [UW-1:0]    seg_bytes,
  output logic [UW-1:0]    used
);

  logic [AW-1:0] head_q, head_d;
  logic [UW-1:0] used_q, used_d;
  logic [UW-1:0] free_bytes, rel_bytes;
  logic          fits;

  assign seg_bytes  = UW'(req_len) + UW'(META_BYTES);
  assign rel_bytes  = UW'(rel_len) + UW'(META_BYTES);
  assign free_bytes = UW'(MEM_BYTES) - used_q;
  assign fits       = (seg_bytes <= free_bytes);
  assign grant      = req && !blocked && fits;
  assign drop       = req && !grant;
  assign seg_start  = head_q;
  assign used       = used_q;

  always_comb begin
    head_d = head_q;
    used_d = used_q;
    if (grant) begin
      head_d = head_q + AW'(seg_bytes);
      used_d = used_d + seg_bytes;
    end
    if (rel) begin
      used_d = used_d - rel_bytes;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      used_q <= '0;
    end else begin
      head_q <= head_d;
      used_q <= used_d;
    end
  end

endmodule

// File: rtl/rxbuf_fill.sv
module rxbuf_fill #(
  parameter int unsigned AW = 10,
  parameter int unsigned UW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          load_ok,
  input  logic [AW-1:0] base,
  input  logic [UW-1:0] seg,
  input  logic          byte_vld,
  input  logic [7:0]    byte_in,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [7:0]    wdata
);

  logic [AW-1:0] wp_q, wp_d;
  logic [UW-1:0] rem_q, rem_d;
  logic          take;

  // a byte in the announce cycle is not taken
  assign take  = byte_vld && (rem_q != '0) && !load;
  assign we    = take;
  assign waddr = wp_q;
  assign wdata = byte_in;

  always_comb begin
    wp_d  = wp_q;
    rem_d = rem_q;
    if (load) begin
      rem_d = load_ok ? seg : '0;
      if (load_ok) begin
        wp_d = base;
      end
    end else if (take) begin
      rem_d = rem_q - 1'b1;
      wp_d  = wp_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rem_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rem_q <= rem_d;
    end
  end

endmodule

// File: rtl/rxbuf_store.sv
module rxbuf_store #(
  parameter  int unsigned BYTES = 1024,
  localparam int unsigned AW    = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] cell_q [BYTES];
  logic [7:0] rdata_q;

  assign rdata = rdata_q;

  always_ff @(posedge clk) begin
    if (we) begin
      cell_q[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (re) begin
      rdata_q <= cell_q[raddr];
    end
  end

endmodule

// File: rtl/rx_pkt_buffer.sv
module rx_pkt_buffer
  import rxbuf_pkg::*;
#(
  parameter  int unsigned MEM_BYTES  = 1024,
  parameter  int unsigned DESC_DEPTH = 16,
  parameter  int unsigned LEN_W      = 8,
  parameter  int unsigned META_BYTES = 16,
  localparam int unsigned AW         = $clog2(MEM_BYTES),
  localparam int unsigned CW         = $clog2(DESC_DEPTH + 1),
  localparam int unsigned UW         = $clog2(MEM_BYTES + 1),
  localparam int unsigned HDW        = (AW > LEN_W) ? AW : LEN_W,
  localparam int unsigned DW         = AW + LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_start,
  input  logic [LEN_W-1:0] wr_len,
  input  logic             wr_valid,
  input  logic [7:0]       wr_byte,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [1:0]       host_addr,
  input  logic [HDW-1:0]   host_wdata,
  output logic [HDW-1:0]   host_rdata,
  output logic [CW-1:0]    pkt_count,
  output logic             ovf
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  // host decode
  rxb_addr_e addr_e;
  logic      cmd_next, ptr_load, data_rd;

  assign addr_e   = rxb_addr_e'(host_addr);
  assign cmd_next = host_wr && (addr_e == RXB_A_CTRL) && host_wdata[RXB_CMD_NEXT_BIT];
  assign ptr_load = host_wr && (addr_e == RXB_A_START);
  assign data_rd  = host_rd && (addr_e == RXB_A_DATA);

  // allocation
  logic             grant, drop, fifo_full, fifo_empty, pop_ok, rel;
  logic [AW-1:0]    seg_start;
  logic [UW-1:0]    seg_bytes, used_bytes;
  logic [DW-1:0]    fifo_dout;
  logic [CW-1:0]    fifo_count;
  logic [AW-1:0]    cur_start_q, cur_start_d;
  logic [LEN_W-1:0] cur_len_q, cur_len_d;
  logic             cur_vld_q, cur_vld_d;

  assign pop_ok = cmd_next && !fifo_empty;
  assign rel    = pop_ok && cur_vld_q;

  rxbuf_alloc #(
    .MEM_BYTES (MEM_BYTES),
    .LEN_W     (LEN_W),
    .META_BYTES(META_BYTES)
  ) alloc_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .req      (wr_start),
    .req_len  (wr_len),
    .blocked  (fifo_full),
    .rel      (rel),
    .rel_len  (cur_len_q),
    .grant    (grant),
    .drop     (drop),
    .seg_start(seg_start),
    .seg_bytes(seg_bytes),
    .used     (used_bytes)
  );

  rxbuf_desc_fifo #(
    .DEPTH(DESC_DEPTH),
    .W    (DW)
  ) fifo_i (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .push (grant),
    .din  ({seg_start, wr_len}),
    .pop  (cmd_next),
    .dout (fifo_dout),
    .full (fifo_full),
    .empty(fifo_empty),
    .count(fifo_count)
  );

  // writer byte path
  logic          st_we;
  logic [AW-1:0] st_waddr;
  logic [7:0]    st_wdata, st_rdata;

  rxbuf_fill #(
    .AW(AW),
    .UW(UW)
  ) fill_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (wr_start),
    .load_ok (grant),
    .base    (seg_start),
    .seg     (seg_bytes),
    .byte_vld(wr_valid),
    .byte_in (wr_byte),
    .we      (st_we),
    .waddr   (st_waddr),
    .wdata   (st_wdata)
  );

  // read pointer
  logic [AW-1:0] ptr_q, ptr_d;

  rxbuf_store #(
    .BYTES(MEM_BYTES)
  ) store_i (
    .clk  (clk),
    .we   (st_we),
    .waddr(st_waddr),
    .wdata(st_wdata),
    .re   (data_rd),
    .raddr(ptr_q),
    .rdata(st_rdata)
  );

  // current descriptor and pointer
  always_comb begin
    cur_start_d = cur_start_q;
    cur_len_d   = cur_len_q;
    cur_vld_d   = cur_vld_q;
    if (pop_ok) begin
      cur_start_d = fifo_dout[DW-1:LEN_W];
      cur_len_d   = fifo_dout[LEN_W-1:0];
      cur_vld_d   = 1'b1;
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_load) begin
      ptr_d = host_wdata[AW-1:0];
    end else if (data_rd) begin
      ptr_d = ptr_q + 1'b1;
    end
  end

  // host read register
  logic           rd_is_data_q, rd_is_data_d;
  logic [HDW-1:0] rd_reg_q, rd_reg_d;
  logic           ovf_q, ovf_d;

  always_comb begin
    rd_is_data_d = rd_is_data_q;
    rd_reg_d     = rd_reg_q;
    if (host_rd) begin
      rd_is_data_d = (addr_e == RXB_A_DATA);
      case (addr_e)
        RXB_A_CTRL:  rd_reg_d = HDW'(fifo_count);
        RXB_A_START: rd_reg_d = HDW'(cur_start_q);
        RXB_A_LEN:   rd_reg_d = HDW'(cur_len_q);
        default:     rd_reg_d = rd_reg_q;
      endcase
    end
  end

  assign ovf_d = ovf_q || drop;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cur_start_q  <= '0;
      cur_len_q    <= '0;
      cur_vld_q    <= 1'b0;
      ptr_q        <= '0;
      rd_is_data_q <= 1'b0;
      rd_reg_q     <= '0;
      ovf_q        <= 1'b0;
    end else begin
      cur_start_q  <= cur_start_d;
      cur_len_q    <= cur_len_d;
      cur_vld_q    <= cur_vld_d;
      ptr_q        <= ptr_d;
      rd_is_data_q <= rd_is_data_d;
      rd_reg_q     <= rd_reg_d;
      ovf_q        <= ovf_d;
    end
  end

  assign host_rdata = rd_is_data_q ? HDW'(st_rdata) : rd_reg_q;
  assign pkt_count  = fifo_count;
  assign ovf        = ovf_q;

endmodule

// File: rtl/rx_pkt_buffer_chk.sv
module rx_pkt_buffer_chk #(
  parameter int unsigned DESC_DEPTH = 16,
  parameter int unsigned MEM_BYTES  = 1024,
  parameter int unsigned CW         = 5,
  parameter int unsigned UW         = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_next,
  input logic          grant,
  input logic          drop,
  input logic [CW-1:0] pkt_count,
  input logic          ovf,
  input logic [UW-1:0] used
);

  logic pop_req;
  assign pop_req = cmd_next && (pkt_count != '0);

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_count <= CW'(DESC_DEPTH));

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_count == $past(pkt_count)) ||
    (pkt_count == CW'($past(pkt_count) + 1'b1)) ||
    (CW'(pkt_count + 1'b1) == $past(pkt_count)));

  p_grant_raises_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !pop_req) |=> (pkt_count == CW'($past(pkt_count) + 1'b1)));

  p_full_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pkt_count == CW'(DESC_DEPTH)) && !pop_req) |=> (pkt_count == CW'(DESC_DEPTH)));

  p_drop_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovf);

  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  p_used_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    used <= UW'(MEM_BYTES));

  p_used_moves_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant && !pop_req) |=> $stable(used));

  p_next_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_next && (pkt_count == '0) && !grant) |=> ((pkt_count == '0) && $stable(used)));

endmodule

bind rx_pkt_buffer rx_pkt_buffer_chk #(
  .DESC_DEPTH(DESC_DEPTH),
  .MEM_BYTES (MEM_BYTES),
  .CW        (CW),
  .UW        (UW)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .cmd_next (cmd_next),
  .grant    (grant),
  .drop     (drop),
  .pkt_count(pkt_count),
  .ovf      (ovf),
  .used     (used_bytes)
);

// File: tb/rx_pkt_buffer_tb_top.sv
module rx_pkt_buffer_tb_top;

  localparam int MEMB  = 1024;
  localparam int QD    = 16;
  localparam int META  = 16;

  logic       clk;
  logic       rst_n;
  logic       wr_start;
  logic [7:0] wr_len;
  logic       wr_valid;
  logic [7:0] wr_byte;
  logic       host_wr;
  logic       host_rd;
  logic [1:0] host_addr;
  logic [9:0] host_wdata;
  logic [9:0] host_rdata;
  logic [4:0] pkt_count;
  logic       ovf;

  rx_pkt_buffer dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_start  (wr_start),
    .wr_len    (wr_len),
    .wr_valid  (wr_valid),
    .wr_byte   (wr_byte),
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .host_addr (host_addr),
    .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .pkt_count (pkt_count),
    .ovf       (ovf)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int tests = 0;
  int fails = 0;

  // reference model state, built from the requirements
  int p_start[$];
  int p_len[$];
  int p_id[$];
  int head_m  = 0;
  int used_m  = 0;
  int cur_s   = 0;
  int cur_l   = 0;
  int cur_id  = 0;
  bit cur_v   = 0;
  bit ovf_m   = 0;

  // scoreboard
  int    exp_q[$];
  string tag_q[$];
  logic  rd_seen = 1'b0;

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= host_rd;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      chk(tag_q.pop_front(), int'(host_rdata), exp_q.pop_front());
    end
  end

  function automatic int pb(int id, int len, int i);
    if (i < len)           return (id * 29 + i * 7 + 1) & 255;
    else if (i == len)     return id % 8;                                   // channel
    else if (i == len + 1) return ((7 + id % 6) << 4) | ((1 + id % 4) << 1) | 1; // sf, cr, crc
    else                   return (i * 11 + id) & 255;
  endfunction

  task automatic read_reg(int addr, int exp, string tag);
    host_rd   = 1'b1;
    host_addr = 2'(addr);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    host_rd   = 1'b0;
  endtask

  task automatic write_reg(int addr, int val);
    host_wr    = 1'b1;
    host_addr  = 2'(addr);
    host_wdata = 10'(val);
    @(negedge clk);
    host_wr    = 1'b0;
  endtask

  task automatic send_pkt(int id, int len, string tag);
    int  seg = len + META;
    bit  acc = (p_id.size() < QD) && (MEMB - used_m >= seg);
    wr_start = 1'b1;
    wr_len   = 8'(len);
    @(negedge clk);
    wr_start = 1'b0;
    if (acc) begin
      p_start.push_back(head_m);
      p_len.push_back(len);
      p_id.push_back(id);
      head_m = (head_m + seg) % MEMB;
      used_m += seg;
    end else begin
      ovf_m = 1'b1;
    end
    chk({tag, " count"}, int'(pkt_count), p_id.size());
    chk({tag, " ovf"}, int'(ovf), int'(ovf_m));
    for (int i = 0; i < seg; i++) begin
      wr_valid = 1'b1;
      wr_byte  = 8'(pb(id, len, i));
      @(negedge clk);
    end
    wr_valid = 1'b0;
  endtask

  task automatic next_cmd(string tag);
    write_reg(0, 1);
    if (p_id.size() > 0) begin
      if (cur_v) used_m -= cur_l + META;
      cur_s  = p_start.pop_front();
      cur_l  = p_len.pop_front();
      cur_id = p_id.pop_front();
      cur_v  = 1'b1;
    end
    chk({tag, " count after advance"}, int'(pkt_count), p_id.size());
  endtask

  task automatic chk_desc(string tag);
    read_reg(1, cur_s, {tag, " start"});
    read_reg(2, cur_l, {tag, " length"});
  endtask

  task automatic read_pkt(string tag);
    write_reg(1, cur_s);
    for (int i = 0; i < cur_l + META; i++) begin
      read_reg(3, pb(cur_id, cur_l, i), tag);
    end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_start = 1'b0; wr_len = '0; wr_valid = 1'b0; wr_byte = '0;
    host_wr = 1'b0; host_rd = 1'b0; host_addr = '0; host_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 count", int'(pkt_count), 0);
    chk("R1 ovf", int'(ovf), 0);
    chk("R1 rdata", int'(host_rdata), 0);
    chk_desc("R1");

    // R10 advance with nothing pending
    next_cmd("R10");
    chk_desc("R10 empty queue");
    read_reg(0, 0, "R10 status");

    // R2 R5 R6 R7 two packets
    send_pkt(1, 10, "R2 first");
    send_pkt(2, 3, "R2 second");
    read_reg(0, 2, "R2 status");
    next_cmd("R5");
    chk_desc("R5 first");
    read_pkt("R7 first");
    // R11 hold
    repeat (3) @(negedge clk);
    chk("R11 hold", int'(host_rdata), pb(1, 10, 25));
    next_cmd("R6");
    chk_desc("R6 second");
    read_pkt("R7 second");

    // R4 R9 space refusal and reclaim
    send_pkt(3, 255, "R6 big a");
    send_pkt(4, 255, "R6 big b");
    send_pkt(5, 255, "R6 big c");
    send_pkt(6, 190, "R4 no room");
    next_cmd("R9");
    send_pkt(7, 190, "R9 fits after free");
    next_cmd("R9 a");
    next_cmd("R9 b");
    next_cmd("R8");
    chk_desc("R8 wrap descriptor");
    read_pkt("R8 wrap data");

    // R3 descriptor queue full
    for (int k = 0; k < QD; k++) send_pkt(10 + k, 0, "R3 fill");
    send_pkt(40, 0, "R3 refused");
    for (int k = 0; k < QD; k++) begin
      next_cmd("R3 drain");
      chk_desc("R3 drain");
    end
    next_cmd("R10 drained");
    chk_desc("R10 drained");
    send_pkt(41, 2, "R3 after refusal");
    next_cmd("R3 after refusal");
    chk_desc("R3 no reservation");
    read_pkt("R7 after refusal");
    chk("R4 sticky", int'(ovf), 1);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule